// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block holds the replacement history for a four-way set-associative cache and names the way to evict when a line must be filled. Every set keeps three history bits arranged as a small binary tree. The root bit points at the pair of ways that was used less recently. Each of the two leaf bits points at the less recently used way inside its pair.

The caller presents a set index together with the four valid bits of that set. The block returns the victim way combinationally, both as a 2-bit index and as a one-hot vector. A way that is not valid is always taken ahead of the history. On the clock edge that carries an access strobe or a fill request, the history of the addressed set is updated so that the used way becomes most recently used. A fill counts as an access to the way the block has just named. Tag compare, the data arrays and refill sequencing are handled elsewhere.

Top module: `plru4_victim_sel`

## Requirements
- R1: After reset every set's history is all zero, so with all four ways valid the victim of every set is way 0.
- R2: If any valid bit of the addressed set is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the history holds.
- R3: With all four ways valid, a root bit of 0 picks the pair {0,1} and a root bit of 1 picks the pair {2,3}. Inside {0,1} a leaf-A bit of 0 gives way 0 and 1 gives way 1. Inside {2,3} a leaf-B bit of 0 gives way 2 and 1 gives way 3.
- R4: An access to way 0 sets root=1 and leaf-A=1. Way 1 sets root=1 and leaf-A=0. Way 2 sets root=0 and leaf-B=1. Way 3 sets root=0 and leaf-B=0. The accessed way is therefore never the victim of that set on the next cycle while all ways stay valid.
- R5: An access leaves the leaf bit of the other pair unchanged.
- R6: A fill request (`fill_req`=1) updates the history as an access to the current victim way. `acc_way` is ignored while `fill_req` is high, even if `acc_en` is also high.
- R7: An access or fill changes only the history of the addressed set. All other sets keep their state.
- R8: `victim_oh` has exactly one bit set, at bit position `victim_way`.
- R9: The victim outputs follow `set_idx` and `set_valid` in the same cycle. A history update becomes visible only after the clock edge that carries the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | SET_W | Set addressed for both lookup and update |
| set_valid | input | 4 | Valid bits of the four ways of the addressed set (bit i = way i) |
| acc_en | input | 1 | Access strobe: mark `acc_way` most recently used |
| acc_way | input | 2 | Way that was accessed |
| fill_req | input | 1 | Fill request: mark the current victim most recently used |
| victim_way | output | 2 | Victim way index |
| victim_oh | output | 4 | Victim way, one-hot |

## Verification
The assertions check four properties on every cycle. First, an invalid way wins and all lower-numbered ways are valid. Second, the one-hot output agrees with the index. Third, a just-accessed way is not named again for the same fully valid set. Fourth, the opposite pair's leaf bit and every unaddressed set hold their values. These properties cannot show that the tree encoding picks exactly the right way in every state, or that a fill takes priority over a simultaneous access. The bench's behavioural model shows both by comparing the outputs on every step. It runs through reset, invalid-way patterns, directed access sequences, mixed fill and access, set isolation and a long random stream.

// File: rtl/plru4_pkg.sv
package plru4_pkg;
   localparam int WAYS  = 4;
   localparam int WAY_W = 2;

   // root: 0 -> pair {0,1} older, 1 -> pair {2,3} older
   // lf_a: victim inside {0,1}; lf_b: victim inside {2,3}
   typedef struct packed {
      logic lf_b;
      logic lf_a;
      logic root;
   } plru_hist_t;

   localparam int HIST_W = $bits(plru_hist_t);
endpackage

// File: rtl/plru4_pick.sv
module plru4_pick
   import plru4_pkg::*;
(
   input  plru_hist_t          hist,
   input  logic [WAYS-1:0]     valid,
   output logic [WAY_W-1:0]    way,
   output logic [WAYS-1:0]     way_oh
);
   logic             any_free;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] tree_way;

   assign any_free = ~(&valid);

   // lowest-numbered non-valid way; scan from the top so the lowest wins
   always_comb begin
      free_way = '0;
      for (int i = WAYS-1; i >= 0; i--) begin
         if (!valid[i]) free_way = WAY_W'(i);
      end
   end

   // tree walk: root chooses the pair, the pair's leaf chooses the way
   always_comb begin
      if (hist.root) tree_way = {1'b1, hist.lf_b};
      else           tree_way = {1'b0, hist.lf_a};
   end

   assign way = any_free ? free_way : tree_way;

   for (genvar g = 0; g < WAYS; g++) begin : g_oh
      assign way_oh[g] = (way == WAY_W'(g));
   end
endmodule

// File: rtl/plru4_touch.sv
module plru4_touch
   import plru4_pkg::*;
(
   input  plru_hist_t       cur,
   input  logic [WAY_W-1:0] way,
   output plru_hist_t       nxt
);
   // make 'way' most recently used: point every bit on its path away from it
   always_comb begin
      nxt = cur;
      unique case (way)
         2'd0: begin nxt.root = 1'b1; nxt.lf_a = 1'b1; end
         2'd1: begin nxt.root = 1'b1; nxt.lf_a = 1'b0; end
         2'd2: begin nxt.root = 1'b0; nxt.lf_b = 1'b1; end
         default: begin nxt.root = 1'b0; nxt.lf_b = 1'b0; end
      endcase
   end
endmodule

// File: rtl/plru4_store.sv
module plru4_store
   import plru4_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] idx,
   output plru_hist_t       rd_hist,
   input  logic             we,
   input  plru_hist_t       wr_hist
);
   plru_hist_t regs [NUM_SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) regs[s] <= '0;
      end else if (we && (int'(idx) < NUM_SETS)) begin
         regs[idx] <= wr_hist;
      end
   end

   assign rd_hist = (int'(idx) < NUM_SETS) ? regs[idx] : '0;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_hold
      // R7
      set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && idx == SET_W'(s)) |=> $stable(regs[s]));
   end
endmodule

// File: rtl/plru4_victim_sel.sv
module plru4_victim_sel
   import plru4_pkg::*;
#(
   parameter int NUM_SETS = 16,
   localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic [3:0]       set_valid,
   input  logic             acc_en,
   input  logic [1:0]       acc_way,
   input  logic             fill_req,
   output logic [1:0]       victim_way,
   output logic [3:0]       victim_oh
);
   if (NUM_SETS < 1) begin : g_bad_sets
      $error("plru4_victim_sel: NUM_SETS must be at least 1");
   end
   if (WAYS != 4 || WAY_W != 2) begin : g_bad_ways
      $error("plru4_victim_sel: tree layout is fixed at four ways");
   end

   plru_hist_t       cur_hist;
   plru_hist_t       nxt_hist;
   logic             upd_en;
   logic [WAY_W-1:0] upd_way;

   plru4_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (set_idx),
      .rd_hist (cur_hist),
      .we      (upd_en),
      .wr_hist (nxt_hist)
   );

   plru4_pick i_pick (
      .hist   (cur_hist),
      .valid  (set_valid),
      .way    (victim_way),
      .way_oh (victim_oh)
   );

   // a fill takes precedence and touches the way just named
   assign upd_en  = acc_en | fill_req;
   assign upd_way = fill_req ? victim_way : acc_way;

   plru4_touch i_touch (
      .cur (cur_hist),
      .way (upd_way),
      .nxt (nxt_hist)
   );

   logic [3:0] below_mask;
   assign below_mask = (4'b0001 << victim_way) - 4'b0001;

   // R2
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&set_valid) |-> (!set_valid[victim_way] && ((set_valid & below_mask) == below_mask)));

   // R8
   oh_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(victim_oh) == 1) && victim_oh[victim_way]);

   // R4
   mru_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (set_idx != $past(set_idx)) || !(&set_valid) || (victim_way != $past(upd_way)));

   // R5
   keep_b_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_way[1]) |=> (set_idx != $past(set_idx)) || (cur_hist.lf_b == $past(cur_hist.lf_b)));

   // R5
   keep_a_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_way[1]) |=> (set_idx != $past(set_idx)) || (cur_hist.lf_a == $past(cur_hist.lf_a)));
endmodule

// File: tb/test_plru4_victim_sel.sv
module test_plru4_victim_sel;
   localparam int NS = 16;
   localparam int SW = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] set_idx = '0;
   logic [3:0]    set_valid = 4'hF;
   logic          acc_en = 1'b0;
   logic [1:0]    acc_way = '0;
   logic          fill_req = 1'b0;
   logic [1:0]    victim_way;
   logic [3:0]    victim_oh;

   int n_cmp = 0;
   int n_bad = 0;
   int m_root [NS];
   int m_la   [NS];
   int m_lb   [NS];

   always #10 clk = ~clk;

   plru4_victim_sel #(.NUM_SETS(NS)) i_plru4_victim_sel (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .set_valid(set_valid),
      .acc_en(acc_en), .acc_way(acc_way), .fill_req(fill_req),
      .victim_way(victim_way), .victim_oh(victim_oh)
   );

   function automatic int model_victim(int s, logic [3:0] v);
      for (int i = 0; i < 4; i++) if (v[i] == 1'b0) return i;
      if (m_root[s] == 0) return (m_la[s] == 0) ? 0 : 1;
      return (m_lb[s] == 0) ? 2 : 3;
   endfunction

   task automatic model_touch(int s, int w);
      if (w == 0) begin m_root[s] = 1; m_la[s] = 1; end
      else if (w == 1) begin m_root[s] = 1; m_la[s] = 0; end
      else if (w == 2) begin m_root[s] = 0; m_lb[s] = 1; end
      else begin m_root[s] = 0; m_lb[s] = 0; end
   endtask

   task automatic step(input int s, input logic [3:0] v, input bit acc,
                       input int w, input bit fill, input string tag);
      int exp_w;
      @(negedge clk);
      set_idx = SW'(s); set_valid = v; acc_en = acc; acc_way = 2'(w); fill_req = fill;
      #1;
      exp_w = model_victim(s, v);
      n_cmp++;
      if (int'(victim_way) != exp_w) begin
         n_bad++;
         $display("FAIL %s set %0d valid %b: victim_way %0d expected %0d", tag, s, v, victim_way, exp_w);
      end
      n_cmp++;
      if (victim_oh != (4'b0001 << exp_w)) begin
         n_bad++;
         $display("FAIL R8 set %0d: victim_oh %b expected %b", s, victim_oh, 4'b0001 << exp_w);
      end
      @(posedge clk);
      if (fill) model_touch(s, exp_w);
      else if (acc) model_touch(s, w);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      for (int s = 0; s < NS; s++) begin m_root[s] = 0; m_la[s] = 0; m_lb[s] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state, every set points at way 0
      for (int s = 0; s < NS; s++) step(s, 4'hF, 0, 0, 0, "R1");

      // R3 / R4: directed walks through the tree on set 2
      step(2, 4'hF, 1, 0, 0, "R4");   // root=1 lf_a=1
      step(2, 4'hF, 0, 0, 0, "R3");   // expect way 2
      step(2, 4'hF, 1, 2, 0, "R4");   // root=0 lf_b=1
      step(2, 4'hF, 0, 0, 0, "R5");   // lf_a kept at 1: expect way 1
      step(2, 4'hF, 1, 1, 0, "R4");   // root=1 lf_a=0
      step(2, 4'hF, 0, 0, 0, "R5");   // lf_b kept at 1: expect way 3
      step(2, 4'hF, 1, 3, 0, "R4");
      step(2, 4'hF, 0, 0, 0, "R3");   // expect way 0

      // R2: non-valid ways win over history, lowest first
      for (int p = 0; p < 15; p++) step(2, 4'(p), 0, 0, 0, "R2");
      step(2, 4'b1010, 0, 0, 0, "R2");
      step(2, 4'b0111, 0, 0, 0, "R2");

      // R6: fill touches the victim; acc_way ignored during fill
      step(5, 4'hF, 1, 3, 1, "R6");   // victim 0 filled, not way 3
      step(5, 4'hF, 0, 0, 0, "R6");   // expect way 2
      step(5, 4'hF, 1, 0, 1, "R6");
      step(5, 4'hF, 0, 0, 0, "R6");
      step(5, 4'b1011, 0, 0, 1, "R6"); // fill into invalid way 2
      step(5, 4'hF, 0, 0, 0, "R6");

      // R7: hammer set 7, set 8 keeps its reset history
      for (int k = 0; k < 8; k++) step(7, 4'hF, 1, k % 4, 0, "R7");
      step(8, 4'hF, 0, 0, 0, "R7");

      // R9: outputs follow the set index in the same cycle, no strobe
      step(2, 4'hF, 0, 0, 0, "R9");
      step(7, 4'hF, 0, 0, 0, "R9");
      step(2, 4'hF, 0, 0, 0, "R9");

      // random mix
      for (int k = 0; k < 3000; k++) begin
         int s; int w; bit a; bit f; logic [3:0] v;
         s = $urandom_range(NS - 1);
         w = $urandom_range(3);
         a = ($urandom_range(3) != 0);
         f = ($urandom_range(4) == 0);
         v = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : 4'hF;
         step(s, v, a, w, f, "R3");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule